// File: doc/BRIEF.md
# DDR Refresh and Self-Refresh Scheduler

This block sits beside the main command arbiter of a DDR SDRAM controller and takes care of keeping the array refreshed. A free-running interval timer adds one owed refresh every `REFI_CLKS` clocks. The default of 1040 clocks corresponds to an average spacing of 7.8 us at 133 MHz, which covers 8192 rows in 64 ms. Owed refreshes are served one at a time. Each one is a close-all-banks precharge, then a wait of the precharge time, then the auto-refresh command, then a quiet window for the refresh cycle time. The block asks the arbiter for the command bus with `ref_req` and starts only after `ref_gnt`. If the arbiter postpones refreshes until `MAX_OWED` of them are owed, the block raises `ref_urgent` and starts without waiting for the grant.

The block also handles low-power self-refresh. A request on `sr_req` is taken only when the block is idle, no refresh is owed and the post-wake hold has ended. The entry sequence is a precharge of all banks, then the self-refresh command, during which the clock enable goes low. The clock enable stays low while `sr_req` stays high and returns high the cycle after `sr_req` drops. After this wake, non-read commands are held off for `WAKE_NR_CLKS` clocks and reads for `WAKE_RD_CLKS` clocks. The interval timer does not count during self-refresh and restarts from zero on wake.

The command code on `cmd` is meant to be merged into the arbiter's command stream. The codes are 0 for no operation, 1 for precharge-all (address bit 10 high), 2 for auto-refresh and 3 for self-refresh entry.

Top module: `ddr_refresh_sched`

## Requirements
- R1: While `cke` is high the interval timer adds one owed refresh every `REFI_CLKS` clocks. The first increment appears on `owed` `REFI_CLKS` cycles after reset is released. While `cke` is low the timer is held at zero.
- R2: Every auto-refresh (code 2) and every self-refresh entry (code 3) comes exactly `RP_CLKS` cycles after a precharge-all (code 1), with code 0 on `cmd` in between.
- R3: After an auto-refresh, `cmd` shows code 0 for the next `RFC_CLKS`-1 cycles.
- R4: `owed` goes down by one in the cycle after each auto-refresh and up by one after each timer expiry. A simultaneous expiry and refresh leaves it unchanged, and it saturates at `MAX_OWED`.
- R5: `ref_urgent` is high exactly when `owed` equals `MAX_OWED`. While it is high, a refresh sequence starts without `ref_gnt`.
- R6: In all other cases a sequence starts (code 1 on `cmd`) only in the cycle after one in which both `ref_req` and `ref_gnt` were high.
- R7: A self-refresh sequence is started only from a decision cycle with `owed` = 0 and `sr_req` high. Otherwise `sr_req` has no effect and an owed refresh is served instead. `cke` is low in the cycle that carries code 3, and it falls only in that cycle.
- R8: `cke` stays low for at least two cycles. It returns high in the cycle after `sr_req` is sampled low.
- R9: In the first cycle with `cke` high after self-refresh, `hold_nonread` and `hold_read` both rise. They stay high for `WAKE_NR_CLKS` and `WAKE_RD_CLKS` cycles respectively.
- R10: Self-refresh entry clears `owed` to 0. No sequence starts in the cycle after one with `hold_nonread` high.
- R11: During reset `cke` is high, `cmd` is 0, and `owed`, `ref_req`, `ref_urgent` and both hold outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sr_req | input | 1 | Level request to enter and stay in self-refresh |
| ref_gnt | input | 1 | Arbiter grants the command bus to this block |
| ref_req | output | 1 | Block wants, or currently owns, the command bus |
| ref_urgent | output | 1 | Owed count has reached its limit; the grant is overridden |
| cmd | output | 2 | Command to issue: 0 none, 1 precharge-all, 2 auto-refresh, 3 self-refresh entry |
| cke | output | 1 | Clock enable to the memory |
| owed | output | $clog2(MAX_OWED+1) | Number of postponed refreshes |
| hold_nonread | output | 1 | Non-read commands must not be issued |
| hold_read | output | 1 | Read commands must not be issued |

## Verification
A sequence starts one cycle after its decision cycle, so the bench compares each precharge against the grant, urgency and hold it sampled in the previous cycle. The refresh or entry command is due exactly `RP_CLKS` cycles after that precharge, and the next command no sooner than `RFC_CLKS` cycles after the refresh. Changes to `owed` land one cycle after the timer expiry or refresh that causes them. The wake holds rise in the same cycle that `cke` rises. The bench keeps its own counts of cycles since each such event and compares the outputs at the falling edge against them, so every result is sampled in the cycle it is due.

// File: rtl/ddr_refresh_pkg.sv
package ddr_refresh_pkg;
  typedef enum logic [1:0] {
    CMD_NOP  = 2'd0,
    CMD_PREA = 2'd1,
    CMD_AREF = 2'd2,
    CMD_SREF = 2'd3
  } rfs_cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_RPW,
    ST_AREF,
    ST_RFCW,
    ST_SREF,
    ST_SLEEP
  } rfs_state_e;
endpackage

// File: rtl/rfs_interval_timer.sv
module rfs_interval_timer #(
  parameter int REFI_CLKS = 1040
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int TW = $clog2(REFI_CLKS);

  logic [TW-1:0] cnt;

  assign tick = run && (cnt == TW'(REFI_CLKS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (!run || tick) cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/rfs_owed_counter.sv
module rfs_owed_counter #(
  parameter int MAX_OWED = 8,
  localparam int CW = $clog2(MAX_OWED + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          issued,
  input  logic          clear,
  output logic [CW-1:0] owed,
  output logic          urgent
);
  assign urgent = (owed == CW'(MAX_OWED));

  always_ff @(posedge clk) begin
    if (!rst_n) owed <= '0;
    else if (clear) owed <= '0;
    else begin
      case ({tick, issued})
        2'b10:   if (owed != CW'(MAX_OWED)) owed <= owed + 1'b1;
        2'b01:   if (owed != '0) owed <= owed - 1'b1;
        default: owed <= owed;
      endcase
    end
  end
endmodule

// File: rtl/rfs_exit_hold.sv
module rfs_exit_hold #(
  parameter int WAKE_NR_CLKS = 10,
  parameter int WAKE_RD_CLKS = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wake,
  output logic hold_nonread,
  output logic hold_read
);
  localparam int HW = $clog2(WAKE_RD_CLKS + 1);

  logic [HW-1:0] cnt;

  assign hold_read    = (cnt != '0);
  assign hold_nonread = (cnt > HW'(WAKE_RD_CLKS - WAKE_NR_CLKS));

  always_ff @(posedge clk) begin
    if (!rst_n)         cnt <= '0;
    else if (wake)      cnt <= HW'(WAKE_RD_CLKS);
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/rfs_sequencer.sv
module rfs_sequencer
  import ddr_refresh_pkg::*;
#(
  parameter int RP_CLKS  = 3,
  parameter int RFC_CLKS = 10
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     owed_nz,
  input  logic     urgent,
  input  logic     gnt,
  input  logic     sr_req,
  input  logic     hold_nr,
  output rfs_cmd_e cmd,
  output logic     cke,
  output logic     req,
  output logic     issued,
  output logic     clear,
  output logic     wake
);
  localparam int WMAX = (RFC_CLKS > RP_CLKS) ? RFC_CLKS : RP_CLKS;
  localparam int WW   = $clog2(WMAX);

  rfs_state_e    state, nxt;
  logic [WW-1:0] wcnt;
  logic          to_sleep;
  logic          idle, start_ref, start_sr;

  assign idle      = (state == ST_IDLE);
  assign start_ref = idle && !hold_nr && owed_nz && (gnt || urgent);
  assign start_sr  = idle && !hold_nr && !owed_nz && sr_req && gnt;

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE:  if (start_ref || start_sr) nxt = ST_PRE;
      ST_PRE:   nxt = ST_RPW;
      ST_RPW:   if (wcnt == '0) nxt = to_sleep ? ST_SREF : ST_AREF;
      ST_AREF:  nxt = ST_RFCW;
      ST_RFCW:  if (wcnt == '0) nxt = ST_IDLE;
      ST_SREF:  nxt = ST_SLEEP;
      ST_SLEEP: if (!sr_req) nxt = ST_IDLE;
      default:  nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      wcnt     <= '0;
      to_sleep <= 1'b0;
    end else begin
      state <= nxt;
      if (state == ST_PRE)       wcnt <= WW'(RP_CLKS - 2);
      else if (state == ST_AREF) wcnt <= WW'(RFC_CLKS - 2);
      else if (wcnt != '0)       wcnt <= wcnt - 1'b1;
      if (start_sr)       to_sleep <= 1'b1;
      else if (start_ref) to_sleep <= 1'b0;
    end
  end

  always_comb begin
    case (state)
      ST_PRE:  cmd = CMD_PREA;
      ST_AREF: cmd = CMD_AREF;
      ST_SREF: cmd = CMD_SREF;
      default: cmd = CMD_NOP;
    endcase
  end

  assign cke    = !((state == ST_SREF) || (state == ST_SLEEP));
  assign issued = (state == ST_AREF);
  assign clear  = (state == ST_SREF);
  assign wake   = (state == ST_SLEEP) && !sr_req;
  assign req    = !idle || (!hold_nr && (owed_nz || sr_req));
endmodule

// File: rtl/ddr_refresh_sched.sv
module ddr_refresh_sched
  import ddr_refresh_pkg::*;
#(
  parameter int REFI_CLKS    = 1040,
  parameter int RP_CLKS      = 3,
  parameter int RFC_CLKS     = 10,
  parameter int MAX_OWED     = 8,
  parameter int WAKE_NR_CLKS = 10,
  parameter int WAKE_RD_CLKS = 200
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            sr_req,
  input  logic                            ref_gnt,
  output logic                            ref_req,
  output logic                            ref_urgent,
  output logic [1:0]                      cmd,
  output logic                            cke,
  output logic [$clog2(MAX_OWED+1)-1:0]   owed,
  output logic                            hold_nonread,
  output logic                            hold_read
);
  logic     tick, issued, clear, wake;
  rfs_cmd_e cmd_e;

  rfs_interval_timer #(.REFI_CLKS(REFI_CLKS)) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (cke),
    .tick (tick)
  );

  rfs_owed_counter #(.MAX_OWED(MAX_OWED)) u_owed (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick),
    .issued(issued),
    .clear (clear),
    .owed  (owed),
    .urgent(ref_urgent)
  );

  rfs_exit_hold #(
    .WAKE_NR_CLKS(WAKE_NR_CLKS),
    .WAKE_RD_CLKS(WAKE_RD_CLKS)
  ) u_hold (
    .clk         (clk),
    .rst_n       (rst_n),
    .wake        (wake),
    .hold_nonread(hold_nonread),
    .hold_read   (hold_read)
  );

  rfs_sequencer #(
    .RP_CLKS (RP_CLKS),
    .RFC_CLKS(RFC_CLKS)
  ) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .owed_nz(owed != '0),
    .urgent (ref_urgent),
    .gnt    (ref_gnt),
    .sr_req (sr_req),
    .hold_nr(hold_nonread),
    .cmd    (cmd_e),
    .cke    (cke),
    .req    (ref_req),
    .issued (issued),
    .clear  (clear),
    .wake   (wake)
  );

  assign cmd = cmd_e;
endmodule

// File: rtl/ddr_refresh_sched_chk.sv
module ddr_refresh_sched_chk #(
  parameter int RP_CLKS  = 3,
  parameter int RFC_CLKS = 10,
  parameter int MAX_OWED = 8
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic [1:0]                    cmd,
  input logic                          cke,
  input logic [$clog2(MAX_OWED+1)-1:0] owed,
  input logic                          hold_nonread,
  input logic                          hold_read
);
  logic [15:0] since_pre, since_ref;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_pre <= 16'hFFFF;
      since_ref <= 16'hFFFF;
    end else begin
      if (cmd == 2'd1)              since_pre <= 16'd1;
      else if (since_pre != 16'hFFFF) since_pre <= since_pre + 16'd1;
      if (cmd == 2'd2)              since_ref <= 16'd1;
      else if (since_ref != 16'hFFFF) since_ref <= since_ref + 16'd1;
    end
  end

  a_r2_pre_lead: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 2'd2 || cmd == 2'd3) |-> (since_pre == 16'(RP_CLKS)));

  a_r3_rfc_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (since_ref < 16'(RFC_CLKS)) |-> (cmd == 2'd0));

  a_r4_owed_cap: assert property (@(posedge clk) disable iff (!rst_n)
    int'(owed) <= MAX_OWED);

  a_r1_owed_step: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd != 2'd3) |=> (int'(owed) <= int'($past(owed)) + 1));

  a_r7_sref_cke_low: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 2'd3) |-> !cke);

  a_r8_cke_min_low: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cke) |=> !cke);

  a_r9_wake_holds: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke) |-> (hold_nonread && hold_read));

  a_r10_sref_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 2'd3) |=> (owed == '0));
endmodule

bind ddr_refresh_sched ddr_refresh_sched_chk #(
  .RP_CLKS (RP_CLKS),
  .RFC_CLKS(RFC_CLKS),
  .MAX_OWED(MAX_OWED)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmd         (cmd),
  .cke         (cke),
  .owed        (owed),
  .hold_nonread(hold_nonread),
  .hold_read   (hold_read)
);

// File: tb/ddr_refresh_sched_test.sv
`timescale 1ns/1ps
module ddr_refresh_sched_test;
  localparam int REFI = 50;
  localparam int TRP  = 3;
  localparam int TRFC = 10;
  localparam int MAXO = 8;
  localparam int XNR  = 10;
  localparam int XRD  = 200;
  localparam logic [1:0] C_NOP = 2'd0, C_PREA = 2'd1, C_AREF = 2'd2, C_SREF = 2'd3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sr_req = 1'b0;
  logic       ref_gnt = 1'b0;
  logic       ref_req, ref_urgent, cke, hold_nonread, hold_read;
  logic [1:0] cmd;
  logic [3:0] owed;

  always #2.5 clk = ~clk;

  ddr_refresh_sched #(
    .REFI_CLKS(REFI), .RP_CLKS(TRP), .RFC_CLKS(TRFC), .MAX_OWED(MAXO),
    .WAKE_NR_CLKS(XNR), .WAKE_RD_CLKS(XRD)
  ) uut (
    .clk(clk), .rst_n(rst_n), .sr_req(sr_req), .ref_gnt(ref_gnt),
    .ref_req(ref_req), .ref_urgent(ref_urgent), .cmd(cmd), .cke(cke),
    .owed(owed), .hold_nonread(hold_nonread), .hold_read(hold_read)
  );

  int total = 0;
  int bad = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // bench model state
  bit mon_on = 0;
  int bt, exp_owed, since_pre, since_ref, since_rise, low_run;
  int pre_cnt, max_owed_seen;
  bit prev_cke, prev_gnt, prev_urg, prev_hold, prev_sr, prev_req;
  int prev_owed, dec_owed;
  bit dec_sr;

  function automatic int sat_inc(input int v);
    return (v < 100000) ? v + 1 : v;
  endfunction

  always @(negedge clk) begin
    if (mon_on) begin
      bit tick;
      // R1 R4: owed follows timer expiries and refreshes
      chk(int'(owed) == exp_owed, "R1 R4 owed", owed, exp_owed);
      chk(ref_urgent == (int'(owed) == MAXO), "R5 urgent flag", ref_urgent, int'(owed) == MAXO);
      if (int'(owed) > max_owed_seen) max_owed_seen = owed;
      since_pre = sat_inc(since_pre);
      since_ref = sat_inc(since_ref);
      if (cmd == C_PREA) begin
        pre_cnt++;
        chk(prev_req && (prev_gnt || prev_urg), "R6 start needs grant or urgency", prev_gnt, 1);
        chk(!prev_hold, "R10 start during hold", prev_hold, 0);
        dec_owed = prev_owed;
        dec_sr = prev_sr;
        since_pre = 0;
      end else if (since_pre >= 1 && since_pre < TRP) begin
        chk(cmd == C_NOP, "R2 gap after precharge", cmd, C_NOP);
      end
      if (cmd == C_AREF || cmd == C_SREF)
        chk(since_pre == TRP, "R2 precharge lead", since_pre, TRP);
      if (since_ref >= 1 && since_ref < TRFC)
        chk(cmd == C_NOP, "R3 refresh quiet window", cmd, C_NOP);
      if (cmd == C_AREF) since_ref = 0;
      if (cmd == C_SREF) begin
        chk(dec_owed == 0 && dec_sr, "R7 entry only with nothing owed", dec_owed, 0);
        chk(!cke, "R7 cke low on entry", cke, 0);
      end
      if (!cke && prev_cke) chk(cmd == C_SREF, "R7 cke falls only on entry", cmd, C_SREF);
      if (!cke) low_run++;
      if (cke && !prev_cke) begin
        chk(low_run >= 2, "R8 minimum low time", low_run, 2);
        chk(!prev_sr, "R8 wake follows request drop", prev_sr, 0);
        since_rise = 0;
        low_run = 0;
      end else begin
        since_rise = sat_inc(since_rise);
      end
      if (cke) begin
        chk(hold_nonread == (since_rise < XNR), "R9 non-read hold", hold_nonread, since_rise < XNR);
        chk(hold_read == (since_rise < XRD), "R9 read hold", hold_read, since_rise < XRD);
      end
      // advance the model for the next cycle
      tick = cke && (bt == REFI - 1);
      bt = (!cke || tick) ? 0 : bt + 1;
      if (cmd == C_SREF) exp_owed = 0;
      else if (tick && cmd != C_AREF) begin
        if (exp_owed < MAXO) exp_owed++;
      end else if (!tick && cmd == C_AREF) begin
        if (exp_owed > 0) exp_owed--;
      end
      prev_cke = cke; prev_gnt = ref_gnt; prev_urg = ref_urgent;
      prev_hold = hold_nonread; prev_sr = sr_req; prev_req = ref_req;
      prev_owed = owed;
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    step(3);
    @(negedge clk);
    chk(cke == 1'b1, "R11 reset cke", cke, 1);
    chk(cmd == C_NOP, "R11 reset cmd", cmd, 0);
    chk(owed == 0, "R11 reset owed", owed, 0);
    chk(!ref_req && !ref_urgent, "R11 reset req", ref_req, 0);
    chk(!hold_nonread && !hold_read, "R11 reset holds", hold_read, 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    bt = 0; exp_owed = 0; since_pre = 100000; since_ref = 100000;
    since_rise = 100000; low_run = 0; prev_cke = 1; prev_owed = 0;
    dec_owed = 0; dec_sr = 0; pre_cnt = 0; max_owed_seen = 0;
    mon_on = 1;

    // R1: first owed refresh appears after exactly REFI cycles
    step(REFI - 1);
    @(negedge clk);
    chk(owed == 0, "R1 before first expiry", owed, 0);
    step(1);
    @(negedge clk);
    chk(owed == 1, "R1 first expiry", owed, 1);

    // random grants, no self-refresh
    for (int i = 0; i < 3000; i++) begin
      ref_gnt = ($urandom % 3) != 0;
      step(1);
    end

    // R5: withheld grant drives the owed count to its limit
    ref_gnt = 1'b1;
    step(200);
    ref_gnt = 1'b0;
    pre_cnt = 0;
    max_owed_seen = 0;
    step(REFI * 14);
    chk(max_owed_seen == MAXO, "R5 limit reached", max_owed_seen, MAXO);
    chk(pre_cnt > 0, "R5 forced start without grant", pre_cnt, 1);

    // R7: request while refreshes are owed is served as refresh first
    sr_req = 1'b1;
    ref_gnt = 1'b1;
    for (int i = 0; i < 400 && cke; i++) step(1);
    @(negedge clk);
    chk(!cke, "R7 self-refresh reached", cke, 0);
    step(40);
    @(negedge clk);
    chk(!cke && owed == 0, "R10 owed clear in self-refresh", owed, 0);
    sr_req = 1'b0;
    step(1);
    @(negedge clk);
    chk(cke, "R8 wake one cycle after drop", cke, 1);
    chk(hold_nonread && hold_read, "R9 holds at wake", hold_read, 1);
    step(XRD + 20);

    // R8: re-entry soon after wake, shortest possible stay
    sr_req = 1'b1;
    for (int i = 0; i < 100 && cke; i++) step(1);
    sr_req = 1'b0;
    step(XRD);

    // mixed random traffic with self-refresh episodes
    for (int i = 0; i < 9000; i++) begin
      ref_gnt = ($urandom % 4) != 0;
      if ((i % 150) == 0) sr_req = ($urandom % 3) == 0;
      step(1);
    end
    sr_req = 1'b0;
    step(50);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule